// File: doc/BRIEF.md
# Sensor Register Bus Slave (I2C, auto-incrementing pointer)

This block is the serial front end of a small sensor register file. It watches the SCL and SDA lines of an I2C bus, detects START, repeated START and STOP conditions, and answers the fixed 7-bit device address 0x0D. A write transfer loads an internal register pointer and then writes one data byte through a register-file side port. A read is a combined transfer. A write phase sets the pointer, and then a repeated START with the read direction streams bytes back, MSB first. The pointer advances after every byte.

Both bus lines pass through a synchronizer and edge detector clocked by the system clock. That clock must run at least 16 times the bus bit rate, so 100 kHz and 400 kHz buses are both served. SDA is open drain and appears only as an output enable: when it is high, the line is pulled low. The register file answers reads combinationally from `regAddr`. It sees each read through a one-cycle `regRe` strobe and each write through a one-cycle `regWe` strobe. Only the writable window 09h–0Bh produces write strobes. When the register file sets its pointer-wrap control bit, reads that began inside 00h–06h wrap from 06h back to 00h.

Top module: `mag_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 0x0D (0x1A for write, 0x1B for read). Any other address gets no acknowledge, and the slave stays silent until the next START.
- R2: A write transfer (address 0x1A, register byte, data byte) is acknowledged on all three bytes. When the data byte completes, `regWe` pulses for exactly one cycle, carrying the register byte on `regAddr` and the data byte on `regWdata`.
- R3: Only register addresses 09h to 0Bh inclusive are writable. A data byte sent to any other address is still acknowledged, but `regWe` does not pulse.
- R4: One data byte is accepted per write transfer. Further bytes in the same transfer are not acknowledged and cause no write strobe.
- R5: After a repeated START with 0x1B, the slave sends bytes MSB first. Each byte is the value of `regRdata` for the current pointer. `regRe` pulses once per byte, in the cycle the byte is captured, and never in the same cycle as `regWe`.
- R6: The pointer is set by the register byte of the most recent write phase. It increments by one after every byte read.
- R7: The pointer goes from 06h to 00h when both conditions hold: `wrapEnable` is 1, and the read began at an address in 00h–06h.
- R8: The pointer goes from 06h to 07h when `wrapEnable` is 0. When the read began above 06h, the pointer simply increments whatever `wrapEnable` is.
- R9: A master NACK after a read byte ends the read. SDA is released and no further `regRe` pulses occur.
- R10: After reset and after any STOP, `sdaOe` is 0 and the slave waits in idle.
- R11: Correct operation does not depend on bus speed, as long as each SCL high and low phase lasts at least 8 system clocks. `sdaOe` only rises while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| sdaOe | output | 1 | Pull SDA low when 1 (open-drain drive) |
| wrapEnable | input | 1 | Pointer roll-over control bit from the register file |
| regAddr | output | 8 | Register pointer presented to the register file |
| regWdata | output | 8 | Data byte for a register write |
| regWe | output | 1 | One-cycle register write strobe |
| regRdata | input | 8 | Register file read data for `regAddr` |
| regRe | output | 1 | One-cycle strobe marking the capture of a read byte |

## Verification
The assertions assume a well-behaved master. SDA changes only while SCL is low, except at START and STOP edges. Each SCL phase is long enough for the synchronizer to show every edge as a separate event. They also assume the master never tries a STOP while the slave is holding SDA low. The bench master keeps within this: it changes SDA two clocks after lowering SCL, uses phases of at least 10 clocks, and sends STOP only after a NACK or a completed write. One pass repeats a write and a wrapping read with slow phases of 160 clocks, which stands in for a 400 kHz bus.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_MACK,
    ST_SKIP
  } busState_t;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic clrBits;
    logic shiftRx;
    logic shiftTx;
    logic loadPtr;
    logic incPtr;
    logic loadTx;
    logic armWrap;
    logic writeReg;
  } dpCmd_t;

endpackage

// File: rtl/mag_i2c_line_sync.sv
module mag_i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  localparam int LINES = 2;

  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] prev;

  assign rawLines = {sdaIn, sclIn};

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '1;
      else       pipe <= {pipe[STAGES-2:0], rawLines[gi]};
    end
    assign lvl[gi] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prev <= '1;
    else       prev <= lvl;
  end

  assign sclLvl    = lvl[0];
  assign sdaLvl    = lvl[1];
  assign sclRise   = lvl[0] & ~prev[0];
  assign sclFall   = ~lvl[0] & prev[0];
  // SDA edge while SCL stays high on both samples
  assign startSeen = lvl[0] & prev[0] & prev[1] & ~lvl[1];
  assign stopSeen  = lvl[0] & prev[0] & ~prev[1] & lvl[1];

endmodule

// File: rtl/mag_i2c_ctrl.sv
module mag_i2c_ctrl
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h0D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              sdaLvl,
  input  logic              byteDone,
  input  logic              txLast,
  input  logic              txBit,
  input  logic [BYTE_W-1:0] rxByte,
  output dpCmd_t            cmd,
  output logic              sdaOe
);

  busState_t state, nextState;
  logic      isRead;
  logic      nackSeen;

  always_comb begin
    nextState = state;
    cmd       = '0;
    if (startSeen) begin
      nextState   = ST_ADDR;
      cmd.clrBits = 1'b1;
    end else if (stopSeen) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise && !byteDone) cmd.shiftRx = 1'b1;
          else if (sclFall && byteDone)
            nextState = (rxByte[BYTE_W-1:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            cmd.clrBits = 1'b1;
            if (isRead) begin
              nextState   = ST_RDATA;
              cmd.loadTx  = 1'b1;
              cmd.armWrap = 1'b1;
            end else begin
              nextState = ST_REG;
            end
          end
        end
        ST_REG: begin
          if (sclRise && !byteDone) cmd.shiftRx = 1'b1;
          else if (sclFall && byteDone) begin
            nextState   = ST_REG_ACK;
            cmd.loadPtr = 1'b1;
          end
        end
        ST_REG_ACK: begin
          if (sclFall) begin
            nextState   = ST_WDATA;
            cmd.clrBits = 1'b1;
          end
        end
        ST_WDATA: begin
          if (sclRise && !byteDone) cmd.shiftRx = 1'b1;
          else if (sclFall && byteDone) begin
            nextState    = ST_WDATA_ACK;
            cmd.writeReg = 1'b1;
          end
        end
        ST_WDATA_ACK: begin
          if (sclFall) nextState = ST_SKIP;
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (txLast) begin
              nextState  = ST_MACK;
              cmd.incPtr = 1'b1;
            end else begin
              cmd.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclFall) begin
            if (nackSeen) begin
              nextState = ST_SKIP;
            end else begin
              nextState   = ST_RDATA;
              cmd.clrBits = 1'b1;
              cmd.loadTx  = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      isRead   <= 1'b0;
      nackSeen <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_ADDR && nextState == ST_ADDR_ACK) isRead <= rxByte[0];
      if (state == ST_MACK && sclRise) nackSeen <= sdaLvl;
    end
  end

  always_comb begin
    case (state)
      ST_ADDR_ACK, ST_REG_ACK, ST_WDATA_ACK: sdaOe = 1'b1;
      ST_RDATA:                               sdaOe = ~txBit;
      default:                                sdaOe = 1'b0;
    endcase
  end

endmodule

// File: rtl/mag_i2c_datapath.sv
module mag_i2c_datapath
  import i2cs_pkg::*;
#(
  parameter logic [BYTE_W-1:0] WR_FIRST  = 8'h09,
  parameter logic [BYTE_W-1:0] WR_LAST   = 8'h0B,
  parameter logic [BYTE_W-1:0] WRAP_LAST = 8'h06
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              sdaLvl,
  input  logic              wrapEnable,
  input  logic [BYTE_W-1:0] regRdata,
  output logic              byteDone,
  output logic              txLast,
  output logic              txBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] ptr;
  logic              wrapArm;
  logic              wrapNow;
  logic              ptrWritable;

  assign wrapNow     = wrapEnable && wrapArm && (ptr == WRAP_LAST);
  assign ptrWritable = (ptr >= WR_FIRST) && (ptr <= WR_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '1;
      ptr     <= '0;
      wrapArm <= 1'b0;
    end else begin
      if (cmd.clrBits)                     bitCnt <= '0;
      else if (cmd.shiftRx || cmd.shiftTx) bitCnt <= bitCnt + CNT_W'(1);

      if (cmd.shiftRx) rxShift <= {rxShift[BYTE_W-2:0], sdaLvl};

      if (cmd.loadTx)       txShift <= regRdata;
      else if (cmd.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};

      if (cmd.loadPtr)     ptr <= rxShift;
      else if (cmd.incPtr) ptr <= wrapNow ? '0 : ptr + BYTE_W'(1);

      if (cmd.armWrap) wrapArm <= (ptr <= WRAP_LAST);
    end
  end

  assign byteDone = (bitCnt == CNT_W'(BYTE_W));
  assign txLast   = (bitCnt == CNT_W'(BYTE_W - 1));
  assign txBit    = txShift[BYTE_W-1];
  assign rxByte   = rxShift;
  assign regAddr  = ptr;
  assign regWdata = rxShift;
  assign regWe    = cmd.writeReg && ptrWritable;
  assign regRe    = cmd.loadTx;

endmodule

// File: rtl/mag_i2c_slave.sv
module mag_i2c_slave
  import i2cs_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h0D,
  parameter logic [BYTE_W-1:0] WR_FIRST    = 8'h09,
  parameter logic [BYTE_W-1:0] WR_LAST     = 8'h0B,
  parameter logic [BYTE_W-1:0] WRAP_LAST   = 8'h06,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              wrapEnable,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWdata,
  output logic              regWe,
  input  logic [BYTE_W-1:0] regRdata,
  output logic              regRe
);

  logic              sclLvl, sdaLvl, sclRise, sclFall, startSeen, stopSeen;
  logic              byteDone, txLast, txBit;
  logic [BYTE_W-1:0] rxByte;
  dpCmd_t            cmd;

  mag_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  mag_i2c_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaLvl(sdaLvl),
    .byteDone(byteDone), .txLast(txLast), .txBit(txBit), .rxByte(rxByte),
    .cmd(cmd), .sdaOe(sdaOe)
  );

  mag_i2c_datapath #(
    .WR_FIRST(WR_FIRST), .WR_LAST(WR_LAST), .WRAP_LAST(WRAP_LAST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaLvl(sdaLvl),
    .wrapEnable(wrapEnable), .regRdata(regRdata),
    .byteDone(byteDone), .txLast(txLast), .txBit(txBit), .rxByte(rxByte),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRe(regRe)
  );

endmodule

// File: rtl/mag_i2c_slave_chk.sv
module mag_i2c_slave_chk (
  input logic clk,
  input logic rstN,
  input logic sclLvl,
  input logic stopSeen,
  input logic sdaOe,
  input logic regWe,
  input logic regRe
);

  // R2: write strobe lasts one cycle
  p_we_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R2: write strobe fires in the SCL low phase after the data byte
  p_we_scl_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !sclLvl);

  // R5: read strobe lasts one cycle
  p_re_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    regRe |=> !regRe);

  // R5: read and write strobes never coincide
  p_strobes_apart_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regRe));

  // R10: a STOP leaves SDA released
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe);

  // R11: the slave starts pulling SDA only while SCL is low
  p_oe_rise_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclLvl);

endmodule

bind mag_i2c_slave mag_i2c_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .stopSeen(stopSeen),
  .sdaOe(sdaOe), .regWe(regWe), .regRe(regRe)
);

// File: tb/mag_i2c_slave_test.sv
module mag_i2c_slave_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic       sdaBus;
  logic       sdaOe;
  logic       wrapEnable = 1'b0;
  logic [7:0] regAddr, regWdata, regRdata;
  logic       regWe, regRe;

  int compared = 0;
  int mismatched = 0;
  int halfT = 12;
  bit finished = 0;

  logic [15:0] expWe[$];
  logic [7:0]  expRe[$];

  always #4 clk = ~clk;  // 125 MHz

  assign sdaBus = mSda & ~sdaOe;

  function automatic logic [7:0] regVal(input logic [7:0] a);
    return {a[3:0], ~a[3:0]} ^ 8'h3C;
  endfunction

  assign regRdata = regVal(regAddr);

  mag_i2c_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .wrapEnable(wrapEnable), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata), .regRe(regRe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of strobes against the reference queues
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (regWe) begin
        if (expWe.size() == 0) check(0, "R3 unexpected regWe", {regAddr, regWdata}, 0);
        else begin
          logic [15:0] e;
          e = expWe.pop_front();
          check({regAddr, regWdata} == e, "R2 write strobe", {regAddr, regWdata}, e);
        end
      end
      if (regRe) begin
        if (expRe.size() == 0) check(0, "R9 unexpected regRe", regAddr, 0);
        else begin
          logic [7:0] e;
          e = expRe.pop_front();
          check(regAddr == e, "R6 read address", regAddr, e);
        end
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    mSda = 1'b1; mScl = 1'b1; waitClk(halfT);
    mSda = 1'b0; waitClk(halfT);
    mScl = 1'b0; waitClk(2);
  endtask

  task automatic restartCond();
    mSda = 1'b1; waitClk(halfT);
    mScl = 1'b1; waitClk(halfT);
    mSda = 1'b0; waitClk(halfT);
    mScl = 1'b0; waitClk(2);
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitClk(halfT);
    mScl = 1'b1; waitClk(halfT);
    mSda = 1'b1; waitClk(halfT);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitClk(halfT);
      mScl = 1'b1; waitClk(halfT);
      mScl = 1'b0; waitClk(2);
    end
    mSda = 1'b1; waitClk(halfT);
    mScl = 1'b1; waitClk(halfT / 2);
    acked = !sdaBus;
    waitClk(halfT - halfT / 2);
    mScl = 1'b0; waitClk(2);
  endtask

  task automatic recvByte(input bit nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mSda = 1'b1; waitClk(halfT);
      mScl = 1'b1; waitClk(halfT / 2);
      b[i] = sdaBus;
      waitClk(halfT - halfT / 2);
      mScl = 1'b0; waitClk(2);
    end
    mSda = nack; waitClk(halfT);
    mScl = 1'b1; waitClk(halfT);
    mScl = 1'b0; waitClk(2);
    mSda = 1'b1;
  endtask

  task automatic writeTxn(input logic [7:0] ra, input logic [7:0] d, input int extra);
    bit ack;
    bit wr;
    wr = (ra >= 8'h09) && (ra <= 8'h0B);
    startCond();
    sendByte(8'h1A, ack); check(ack, "R1 write address ack", ack, 1);
    sendByte(ra, ack);    check(ack, "R2 register byte ack", ack, 1);
    if (wr) expWe.push_back({ra, d});
    sendByte(d, ack);
    if (wr) check(ack, "R2 data byte ack", ack, 1);
    else    check(ack, "R3 read-only data ack", ack, 1);
    for (int k = 0; k < extra; k++) begin
      sendByte(d ^ 8'hFF, ack);
      check(!ack, "R4 extra byte nack", ack, 0);
    end
    stopCond();
    check(expWe.size() == 0, "R2 write strobe count", expWe.size(), 0);
    check(!sdaOe, "R10 release after stop", sdaOe, 0);
  endtask

  task automatic readTxn(input logic [7:0] sa, input int n, input bit wrap, input string tag);
    bit ack;
    logic [7:0] got;
    logic [7:0] cur;
    bit arm;
    wrapEnable = wrap;
    startCond();
    sendByte(8'h1A, ack); check(ack, "R1 address ack", ack, 1);
    sendByte(sa, ack);    check(ack, "R6 pointer byte ack", ack, 1);
    restartCond();
    cur = sa;
    arm = (sa <= 8'h06);
    expRe.push_back(cur);
    sendByte(8'h1B, ack); check(ack, "R5 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] nxt;
      nxt = (wrap && arm && cur == 8'h06) ? 8'h00 : cur + 8'd1;
      if (i != n - 1) expRe.push_back(nxt);
      recvByte(i == n - 1, got);
      check(got == regVal(cur), tag, got, regVal(cur));
      cur = nxt;
    end
    waitClk(4);
    check(!sdaOe, "R9 release after nack", sdaOe, 0);
    stopCond();
    check(expRe.size() == 0, "R9 read strobe count", expRe.size(), 0);
  endtask

  initial begin
    waitClk(5);
    check(!sdaOe && !regWe && !regRe, "R10 reset outputs", {sdaOe, regWe, regRe}, 0);
    rstN = 1'b1;
    waitClk(5);
    check(!sdaOe, "R10 idle after reset", sdaOe, 0);

    writeTxn(8'h09, 8'h1D, 0);          // R2
    writeTxn(8'h0B, 8'h01, 0);          // R2 upper edge of window
    writeTxn(8'h03, 8'h55, 0);          // R3 read-only
    writeTxn(8'h0C, 8'hAA, 0);          // R3 just above window
    writeTxn(8'h0A, 8'h40, 2);          // R4 extra bytes

    begin : wrong_addr  // R1 mismatch
      bit ack;
      startCond();
      sendByte(8'h1C, ack); check(!ack, "R1 foreign address nack", ack, 0);
      sendByte(8'h09, ack); check(!ack, "R1 silent after mismatch", ack, 0);
      check(!sdaOe, "R1 released after mismatch", sdaOe, 0);
      stopCond();
    end

    readTxn(8'h00, 3, 1'b0, "R5 read bytes from 00h");
    readTxn(8'h04, 5, 1'b1, "R7 wrap 06h to 00h");
    readTxn(8'h05, 3, 1'b0, "R8 no wrap when disabled");
    readTxn(8'h08, 3, 1'b1, "R8 no wrap above window");
    readTxn(8'h06, 2, 1'b1, "R7 wrap from start 06h");

    halfT = 160;  // R11 slow bus
    writeTxn(8'h0A, 8'h01, 0);
    readTxn(8'h05, 4, 1'b1, "R11 slow wrapping read");
    halfT = 10;   // R11 fast bus
    readTxn(8'h02, 2, 1'b0, "R11 fast read");

    waitClk(10);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule